// File: doc/BRIEF.md
# Four-Layer Road Matching Track Linker Slice

This block serves one angular slice of a track trigger. Each beam crossing, an upstream segment finder delivers two things for each of four axial layers: a vector of fired pixels, and for every pixel a set of slope-bin flags. The block holds a fixed table of valid roads as a parameter. A road names one pixel and one slope bin in each layer, plus the momentum code and phi code that a track along that road implies. All roads are tested at the same time. A road is satisfied only when every layer agrees on both pixel and slope.

The layers can have different numbers of slope bins. The default is none on the two inner layers and two on the two outer layers. A layer with no slope bins is matched on its pixel alone. Satisfied roads are reported one per cycle, highest momentum first, up to a fixed number of track slots per crossing. An overflow flag shows that more roads matched than there were slots.

Each crossing takes a fixed number of cycles: capture, match, then one cycle per track slot. This fits well inside a crossing period. A done strobe marks the last slot.

Top module: `lnk_road_linker`

## Requirements
- R1: While reset is held and in the first cycle after it, `trk_valid_o`, `done_o`, `overflow_o` and `busy_o` are all 0.
- R2: Pixel `p` of layer `l` is bit `l*NPIX+p` of `pix_i`. A road can match only if, in every layer, the pixel at that road's index is fired in the captured crossing.
- R3: The flag for bin `b` of pixel `p` in layer `l` is bit `(l*NPIX+p)*5+b` of `slope_i`. In a layer whose bin count is nonzero, a road matches only if the flag for its slope bin on its pixel is set.
- R4: In a layer whose bin count is zero, slope flags have no effect. The road matches on that layer's pixel alone.
- R5: A slope flag at a bin index equal to or above the layer's bin count is ignored. A road whose own bin in such a layer is out of range never matches.
- R6: Matched roads come out one per valid cycle with the road's momentum and phi codes. Momentum never increases from one track to the next. Roads with equal momentum come out lowest road index first.
- R7: At most `MAX_TRK` tracks are reported per crossing. `overflow_o` is 1 during the done cycle exactly when more than `MAX_TRK` roads matched.
- R8: Track slot `j` (counting from 0) is presented `2+j` cycles after the clock edge that samples `start_i`. Valid tracks fill the first slots. `done_o` is a one-cycle pulse in the last slot, `MAX_TRK+1` cycles after the start edge.
- R9: `busy_o` is 1 from the cycle after the start edge up to, but not including, the done cycle. A `start_i` seen while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture this crossing's inputs and begin evaluation |
| pix_i | input | 4*NPIX | Fired-pixel flags, layer-major |
| slope_i | input | 4*NPIX*5 | Slope-bin flags, five per pixel |
| busy_o | output | 1 | A crossing is being evaluated |
| trk_valid_o | output | 1 | Track slot holds a track |
| trk_pt_o | output | 4 | Momentum code of the track |
| trk_phi_o | output | 5 | Phi code of the track |
| done_o | output | 1 | Last track slot of the crossing |
| overflow_o | output | 1 | More roads matched than slots, valid with done |

## Verification
The bench uses its own road table. The two inner layers have no slope bins, and the outer layers have two and three bins.

Each corner case targets a specific kind of error:
- A matcher that ignored slope would report a road whose pixels all fire but whose outer-layer bin flag is wrong.
- A matcher that read slope on a zero-bin layer would drop a road that should match.
- A matcher that did not mask out-of-range bins would accept a road whose bin lies past the layer's count.

Two roads with the same momentum are fired together, which exposes a wrong tie order. Four matches against three slots check the overflow flag and the cap. Exactly three matches check that the flag stays low at the cap. A second start issued mid-crossing checks that the capture and the done count are not disturbed.

// File: rtl/lnk_pkg.sv
// Shared types and constants for the road-matching linker slice.
// Assumes four axial layers, at most 8 pixels per layer and at most 5
// slope bins per pixel; road fields are sized for those limits.
package lnk_pkg;

    localparam int NLAYER     = 4;
    localparam int PIX_IDX_W  = 3;
    localparam int SB_IDX_W   = 3;
    localparam int MAX_SB     = 5;
    localparam int BINS_W     = 3;
    localparam int PT_W       = 4;
    localparam int PHI_W      = 5;
    localparam int DEF_NROADS = 16;

    // One road: a pixel and a slope bin per layer, plus the implied track.
    typedef struct packed {
        logic [NLAYER-1:0][PIX_IDX_W-1:0] pix;
        logic [NLAYER-1:0][SB_IDX_W-1:0]  sbin;
        logic [PT_W-1:0]                  pt;
        logic [PHI_W-1:0]                 phi;
    } road_t;

    typedef road_t [DEF_NROADS-1:0] road_tab_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_EMIT  = 2'd2
    } lnk_state_e;

    // Computes the default road table (a placeholder set, one road per index).
    function automatic road_tab_t default_table();
        road_tab_t t;
        for (int i = 0; i < DEF_NROADS; i++) begin
            for (int l = 0; l < NLAYER; l++) begin
                t[i].pix[l]  = PIX_IDX_W'((i + l * (i / 4)) % 8);
                t[i].sbin[l] = (l >= 2) ? SB_IDX_W'(i % 2) : '0;
            end
            t[i].pt  = PT_W'(i);
            t[i].phi = PHI_W'(2 * i);
        end
        return t;
    endfunction

endpackage

// File: rtl/lnk_road_match.sv
// Parallel road matcher: one AND term per road, built at elaboration.
// Every road index is a constant, so each layer term reduces to a fixed
// bit select. Assumes pix_q/slope_q are stable registered inputs.
module lnk_road_match #(
    parameter int NPIX   = 8,
    parameter int NROADS = lnk_pkg::DEF_NROADS,
    parameter logic [lnk_pkg::NLAYER*lnk_pkg::BINS_W-1:0] SLOPE_BINS =
        {3'd2, 3'd2, 3'd0, 3'd0},
    parameter lnk_pkg::road_t [NROADS-1:0] ROADS = lnk_pkg::default_table()
) (
    input  logic [lnk_pkg::NLAYER*NPIX-1:0]                 pix_q,
    input  logic [lnk_pkg::NLAYER*NPIX*lnk_pkg::MAX_SB-1:0] slope_q,
    output logic [NROADS-1:0]                               match_o
);
    import lnk_pkg::*;

    for (genvar g = 0; g < NROADS; g++) begin : g_road
        logic [NLAYER-1:0] lm;
        for (genvar l = 0; l < NLAYER; l++) begin : g_layer
            localparam int P    = int'(ROADS[g].pix[l]);
            localparam int B    = int'(ROADS[g].sbin[l]);
            localparam int BINS = int'(SLOPE_BINS[l*BINS_W +: BINS_W]);
            if (P >= NPIX) begin : g_nopix
                assign lm[l] = 1'b0;
            end else if (BINS == 0) begin : g_pixonly
                assign lm[l] = pix_q[l*NPIX + P];
            end else if (B >= BINS || B >= MAX_SB) begin : g_badbin
                assign lm[l] = 1'b0;
            end else begin : g_pixslope
                assign lm[l] = pix_q[l*NPIX + P] & slope_q[(l*NPIX + P)*MAX_SB + B];
            end
        end
        assign match_o[g] = &lm;
    end

endmodule

// File: rtl/lnk_track_pick.sv
// Picks the remaining matched road with the highest momentum code.
// Ties go to the lowest road index, which the strict compare gives.
// Assumes rem_i is registered; a linear scan keeps the logic small.
module lnk_track_pick #(
    parameter int NROADS = lnk_pkg::DEF_NROADS,
    parameter lnk_pkg::road_t [NROADS-1:0] ROADS = lnk_pkg::default_table(),
    localparam int RIDX_W = (NROADS > 1) ? $clog2(NROADS) : 1
) (
    input  logic [NROADS-1:0]          rem_i,
    output logic                       found_o,
    output logic [RIDX_W-1:0]          idx_o,
    output logic [lnk_pkg::PT_W-1:0]   pt_o,
    output logic [lnk_pkg::PHI_W-1:0]  phi_o
);
    import lnk_pkg::*;

    logic [PT_W-1:0]  pt_tab  [NROADS];
    logic [PHI_W-1:0] phi_tab [NROADS];

    for (genvar g = 0; g < NROADS; g++) begin : g_tab
        assign pt_tab[g]  = ROADS[g].pt;
        assign phi_tab[g] = ROADS[g].phi;
    end

    // Scan all roads, keeping the first one with the largest momentum.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pt_o    = '0;
        phi_o   = '0;
        for (int i = 0; i < NROADS; i++) begin
            if (rem_i[i] && (!found_o || pt_tab[i] > pt_o)) begin
                found_o = 1'b1;
                idx_o   = RIDX_W'(i);
                pt_o    = pt_tab[i];
                phi_o   = phi_tab[i];
            end
        end
    end

endmodule

// File: rtl/lnk_road_linker.sv
// Top of one linker slice. Sequence per crossing: capture inputs on start,
// register the match vector and its overflow bit, then emit one track per
// cycle for MAX_TRK slots, highest momentum first, with done on the last.
// Assumes start is issued at most once per crossing; starts while busy drop.
module lnk_road_linker #(
    parameter int NPIX    = 8,
    parameter int NROADS  = lnk_pkg::DEF_NROADS,
    parameter int MAX_TRK = 4,
    parameter logic [lnk_pkg::NLAYER*lnk_pkg::BINS_W-1:0] SLOPE_BINS =
        {3'd2, 3'd2, 3'd0, 3'd0},
    parameter lnk_pkg::road_t [NROADS-1:0] ROADS = lnk_pkg::default_table()
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            start_i,
    input  logic [lnk_pkg::NLAYER*NPIX-1:0]                 pix_i,
    input  logic [lnk_pkg::NLAYER*NPIX*lnk_pkg::MAX_SB-1:0] slope_i,
    output logic                                            busy_o,
    output logic                                            trk_valid_o,
    output logic [lnk_pkg::PT_W-1:0]                        trk_pt_o,
    output logic [lnk_pkg::PHI_W-1:0]                       trk_phi_o,
    output logic                                            done_o,
    output logic                                            overflow_o
);
    import lnk_pkg::*;

    localparam int PIX_W  = NLAYER * NPIX;
    localparam int SLP_W  = NLAYER * NPIX * MAX_SB;
    localparam int RIDX_W = (NROADS > 1) ? $clog2(NROADS) : 1;
    localparam int SLOT_W = (MAX_TRK > 1) ? $clog2(MAX_TRK) : 1;
    localparam int CNT_W  = $clog2(NROADS + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_TRK - 1);
    localparam logic [CNT_W-1:0]  CAP       = CNT_W'(MAX_TRK);

    lnk_state_e          state;
    logic [SLOT_W-1:0]   slot;
    logic [PIX_W-1:0]    pix_q;
    logic [SLP_W-1:0]    slope_q;
    logic [NROADS-1:0]   match_w;
    logic [NROADS-1:0]   rem_q;
    logic                ovf_w;
    logic                ovf_q;
    logic [CNT_W-1:0]    match_cnt;
    logic                pick_found;
    logic [RIDX_W-1:0]   pick_idx;
    logic [PT_W-1:0]     pick_pt;
    logic [PHI_W-1:0]    pick_phi;

    lnk_road_match #(
        .NPIX       (NPIX),
        .NROADS     (NROADS),
        .SLOPE_BINS (SLOPE_BINS),
        .ROADS      (ROADS)
    ) u_match (
        .pix_q   (pix_q),
        .slope_q (slope_q),
        .match_o (match_w)
    );

    lnk_track_pick #(
        .NROADS (NROADS),
        .ROADS  (ROADS)
    ) u_pick (
        .rem_i   (rem_q),
        .found_o (pick_found),
        .idx_o   (pick_idx),
        .pt_o    (pick_pt),
        .phi_o   (pick_phi)
    );

    // Count matched roads and compare against the slot cap.
    always_comb begin
        match_cnt = '0;
        for (int i = 0; i < NROADS; i++) begin
            match_cnt = match_cnt + CNT_W'(match_w[i]);
        end
        ovf_w = (match_cnt > CAP);
    end

    // Sequencer: idle -> match -> emit for MAX_TRK slots -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (start_i) state <= ST_MATCH;
                ST_MATCH: begin
                    state <= ST_EMIT;
                    slot  <= '0;
                end
                ST_EMIT: begin
                    if (slot == LAST_SLOT) state <= ST_IDLE;
                    else                   slot  <= slot + 1'b1;
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Crossing input capture, taken only when a start arrives while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q   <= '0;
            slope_q <= '0;
        end else if (state == ST_IDLE && start_i) begin
            pix_q   <= pix_i;
            slope_q <= slope_i;
        end
    end

    // Pending-road vector: loaded after matching, one bit cleared per emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            ovf_q <= 1'b0;
        end else if (state == ST_MATCH) begin
            rem_q <= match_w;
            ovf_q <= ovf_w;
        end else if (state == ST_EMIT && pick_found) begin
            rem_q[pick_idx] <= 1'b0;
        end
    end

    // Registered track outputs and end-of-crossing strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_valid_o <= 1'b0;
            trk_pt_o    <= '0;
            trk_phi_o   <= '0;
            done_o      <= 1'b0;
            overflow_o  <= 1'b0;
        end else begin
            trk_valid_o <= 1'b0;
            trk_pt_o    <= '0;
            trk_phi_o   <= '0;
            done_o      <= 1'b0;
            overflow_o  <= 1'b0;
            if (state == ST_EMIT) begin
                trk_valid_o <= pick_found;
                trk_pt_o    <= pick_found ? pick_pt  : '0;
                trk_phi_o   <= pick_found ? pick_phi : '0;
                if (slot == LAST_SLOT) begin
                    done_o     <= 1'b1;
                    overflow_o <= ovf_q;
                end
            end
        end
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/lnk_road_linker_chk.sv
// Protocol checker for the linker slice, bound to every instance of the top.
module lnk_road_linker_chk (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy_o,
    input logic                      trk_valid_o,
    input logic [lnk_pkg::PT_W-1:0]  trk_pt_o,
    input logic                      done_o,
    input logic                      overflow_o
);

    // R7: the overflow flag appears only together with done.
    a_r7_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> done_o);

    // R8: done is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: tracks appear only inside the emit window.
    a_r8_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid_o |-> (busy_o || done_o));

    // R9: busy has dropped by the done cycle.
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: momentum never rises between back-to-back tracks.
    a_r6_pt_order: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_valid_o && $past(trk_valid_o)) |-> (trk_pt_o <= $past(trk_pt_o)));

    // R8: once an empty slot is seen inside a window, no track follows it.
    a_r8_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !trk_valid_o && $past(trk_valid_o)) |=> !trk_valid_o);

endmodule

bind lnk_road_linker lnk_road_linker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .trk_valid_o (trk_valid_o),
    .trk_pt_o    (trk_pt_o),
    .done_o      (done_o),
    .overflow_o  (overflow_o)
);

// File: tb/lnk_road_linker_tb_top.sv
// Directed bench for the linker slice: one task per scenario.
module lnk_road_linker_tb_top;
    import lnk_pkg::*;

    localparam int NPIX = 8;
    localparam int NR   = 8;
    localparam int MAXT = 3;
    localparam int SPAN = MAXT + 8;
    localparam int TB_BINS [4] = '{0, 0, 2, 3};

    typedef road_t [NR-1:0] tb_tab_t;

    function automatic road_t mk(int p0, int p1, int p2, int p3,
                                 int s2, int s3, int pt, int phi);
        road_t r;
        r.pix[0] = 3'(p0); r.pix[1] = 3'(p1); r.pix[2] = 3'(p2); r.pix[3] = 3'(p3);
        r.sbin[0] = 3'd0;  r.sbin[1] = 3'd0;  r.sbin[2] = 3'(s2); r.sbin[3] = 3'(s3);
        r.pt  = 4'(pt);
        r.phi = 5'(phi);
        return r;
    endfunction

    function automatic tb_tab_t tb_table();
        tb_tab_t t;
        t[0] = mk(1, 1, 1, 1, 0, 0, 5, 10);
        t[1] = mk(2, 2, 2, 2, 1, 2, 9, 11);
        t[2] = mk(3, 3, 3, 3, 0, 1, 9, 12);
        t[3] = mk(4, 4, 4, 4, 1, 0, 12, 13);
        t[4] = mk(5, 5, 5, 5, 0, 0, 3, 14);
        t[5] = mk(6, 6, 6, 6, 0, 0, 7, 15);
        t[6] = mk(0, 1, 2, 3, 1, 1, 15, 16);
        t[7] = mk(1, 1, 1, 1, 0, 3, 14, 17);
        return t;
    endfunction

    localparam tb_tab_t TB_ROADS = tb_table();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [4*NPIX-1:0]   pix_i = '0;
    logic [4*NPIX*5-1:0] slope_i = '0;
    logic busy_o, trk_valid_o, done_o, overflow_o;
    logic [PT_W-1:0]  trk_pt_o;
    logic [PHI_W-1:0] trk_phi_o;

    always #4 clk = ~clk;

    lnk_road_linker #(
        .NPIX       (NPIX),
        .NROADS     (NR),
        .MAX_TRK    (MAXT),
        .SLOPE_BINS ({3'd3, 3'd2, 3'd0, 3'd0}),
        .ROADS      (TB_ROADS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pix_i       (pix_i),
        .slope_i     (slope_i),
        .busy_o      (busy_o),
        .trk_valid_o (trk_valid_o),
        .trk_pt_o    (trk_pt_o),
        .trk_phi_o   (trk_phi_o),
        .done_o      (done_o),
        .overflow_o  (overflow_o)
    );

    int checks = 0;
    int errors = 0;
    bit hit [4][NPIX];
    bit sfl [4][NPIX][5];
    int exp_pt [MAXT];
    int exp_phi [MAXT];
    int exp_n;
    bit exp_ovf;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_hits();
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < NPIX; p++) begin
                hit[l][p] = 1'b0;
                for (int b = 0; b < 5; b++) sfl[l][p][b] = 1'b0;
            end
    endtask

    task automatic set_hit(int l, int p, int bin);
        hit[l][p] = 1'b1;
        if (bin >= 0) sfl[l][p][bin] = 1'b1;
    endtask

    // Fires a road's pixels and its own slope bins.
    task automatic fire_road(int r);
        for (int l = 0; l < 4; l++)
            set_hit(l, int'(TB_ROADS[r].pix[l]), int'(TB_ROADS[r].sbin[l]));
    endtask

    task automatic pack_inputs();
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < NPIX; p++) begin
                pix_i[l*NPIX+p] = hit[l][p];
                for (int b = 0; b < 5; b++) slope_i[(l*NPIX+p)*5+b] = sfl[l][p][b];
            end
    endtask

    // Reference from the requirements: match test, then momentum-ordered list.
    task automatic model();
        bit m [NR];
        bit used [NR];
        int cnt = 0;
        for (int r = 0; r < NR; r++) begin
            m[r] = 1'b1;
            used[r] = 1'b0;
            for (int l = 0; l < 4; l++) begin
                int p = int'(TB_ROADS[r].pix[l]);
                int b = int'(TB_ROADS[r].sbin[l]);
                if (!hit[l][p]) m[r] = 1'b0;
                if (TB_BINS[l] != 0) begin
                    if (b >= TB_BINS[l]) m[r] = 1'b0;
                    else if (!sfl[l][p][b]) m[r] = 1'b0;
                end
            end
            if (m[r]) cnt++;
        end
        exp_n = 0;
        for (int k = 0; k < MAXT; k++) begin
            int best = -1;
            for (int r = 0; r < NR; r++)
                if (m[r] && !used[r] &&
                    (best < 0 || TB_ROADS[r].pt > TB_ROADS[best].pt)) best = r;
            if (best >= 0) begin
                used[best] = 1'b1;
                exp_pt[k]  = int'(TB_ROADS[best].pt);
                exp_phi[k] = int'(TB_ROADS[best].phi);
                exp_n++;
            end
        end
        exp_ovf = (cnt > MAXT);
    endtask

    // Runs one crossing and compares every slot with the reference.
    // interfere: issue a second start with other data while busy (R9).
    task automatic run_crossing(string req, bit interfere);
        int done_k = -1;
        int done_cnt = 0;
        int got_n = 0;
        model();
        @(negedge clk);
        pack_inputs();
        start_i = 1'b1;
        for (int k = 1; k <= SPAN; k++) begin
            @(negedge clk);
            if (k == 1) chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
            if (done_o) begin
                done_cnt++;
                if (done_k < 0) done_k = k;
                chk(overflow_o == exp_ovf, "R7", "overflow at done", overflow_o, exp_ovf);
                chk(busy_o == 1'b0, "R9", "busy at done", busy_o, 0);
            end
            if (k >= 3 && k <= MAXT + 2) begin
                int j = k - 3;
                bit ev = (j < exp_n);
                chk(trk_valid_o == ev, req, $sformatf("slot %0d valid", j), trk_valid_o, ev);
                if (ev && trk_valid_o) begin
                    chk(int'(trk_pt_o) == exp_pt[j], req, $sformatf("slot %0d pt", j),
                        trk_pt_o, exp_pt[j]);
                    chk(int'(trk_phi_o) == exp_phi[j], req, $sformatf("slot %0d phi", j),
                        trk_phi_o, exp_phi[j]);
                end
                if (trk_valid_o) got_n++;
            end else if (trk_valid_o) begin
                chk(1'b0, "R8", $sformatf("valid outside slots at k=%0d", k), 1, 0);
            end
            start_i = 1'b0;
            if (interfere && k == 2) begin
                clear_hits();
                fire_road(4);
                pack_inputs();
                start_i = 1'b1;
            end
        end
        chk(done_k == MAXT + 2, "R8", "done cycle", done_k, MAXT + 2);
        chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
        chk(got_n == exp_n, "R7", "track count", got_n, exp_n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy_o && !trk_valid_o && !done_o && !overflow_o, "R1",
            "outputs in reset", {busy_o, trk_valid_o, done_o, overflow_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !trk_valid_o && !done_o && !overflow_o, "R1",
            "outputs after reset", {busy_o, trk_valid_o, done_o, overflow_o}, 0);
    endtask

    // R2: a single complete road is reported with its codes.
    task automatic t_single_road();
        clear_hits();
        fire_road(0);
        run_crossing("R2", 1'b0);
        chk(exp_n == 1 && exp_pt[0] == 5, "R2", "reference single road", exp_n, 1);
    endtask

    // R2: one layer's pixel missing kills the road.
    task automatic t_missing_layer();
        clear_hits();
        fire_road(3);
        hit[1][4] = 1'b0;
        run_crossing("R2", 1'b0);
    endtask

    // R3: pixels all fired, outer-layer bin wrong (1 instead of 2) -> no track.
    task automatic t_slope_needed();
        clear_hits();
        for (int l = 0; l < 4; l++) set_hit(l, 2, -1);
        sfl[2][2][1] = 1'b1;
        sfl[3][2][1] = 1'b1;
        run_crossing("R3", 1'b0);
    endtask

    // R4: inner layers with zero bins match on pixel alone, flags there are noise.
    task automatic t_zero_bin_layers();
        clear_hits();
        set_hit(0, 6, -1);
        set_hit(1, 6, 4);
        set_hit(2, 6, 0);
        set_hit(3, 6, 0);
        run_crossing("R4", 1'b0);
    endtask

    // R5: bin 3 on a three-bin layer is out of range; road 7 and road 0 fail.
    task automatic t_bin_beyond_count();
        clear_hits();
        for (int l = 0; l < 4; l++) set_hit(l, 1, -1);
        sfl[2][1][0] = 1'b1;
        sfl[3][1][3] = 1'b1;
        sfl[3][1][4] = 1'b1;
        run_crossing("R5", 1'b0);
    endtask

    // R6: equal momentum 9 on roads 1 and 2 -> phi 11 then 12, then road 4.
    task automatic t_ordering_ties();
        clear_hits();
        fire_road(4);
        fire_road(2);
        fire_road(1);
        run_crossing("R6", 1'b0);
        chk(exp_phi[0] == 11 && exp_phi[1] == 12 && exp_phi[2] == 14 && !exp_ovf,
            "R6", "reference tie order", exp_phi[0], 11);
    endtask

    // R7: four matches against three slots -> 15, 12, 9 and overflow.
    task automatic t_overflow();
        clear_hits();
        fire_road(0);
        fire_road(2);
        fire_road(3);
        fire_road(6);
        run_crossing("R7", 1'b0);
        chk(exp_ovf && exp_pt[0] == 15 && exp_pt[2] == 9, "R7",
            "reference overflow", exp_ovf, 1);
    endtask

    // R9: a start during the busy window is dropped; road 6 result stands.
    task automatic t_busy_ignore();
        clear_hits();
        fire_road(6);
        run_crossing("R9", 1'b1);
    endtask

    initial begin
        clear_hits();
        repeat (3) @(negedge clk);
        t_reset();
        t_single_road();
        t_missing_layer();
        t_slope_needed();
        t_zero_bin_layers();
        t_bin_beyond_count();
        t_ordering_ties();
        t_overflow();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule